// File: doc/BRIEF.md
# Wired Interrupt Pending-State Controller

This block keeps one pending flag for every wired interrupt source of a single machine-level interrupt file. Each source has a stored mode field, and the mode decides how the flag may change: hardware edges, software set and clear writes, and claims by the interrupt handler each have an effect in some modes and none in others. The block also exposes each source's rectified input: the synchronized line, inverted or not or forced low depending on the mode, which is the value the pending logic works from.

Raw lines cross into the clock domain through a synchronizer before any edge detection. Configuration writes, software pending writes and claims are plain single-cycle strobes that carry a source number. They have no handshake because each one is accepted in the cycle it is presented. Source number 0 is reserved and never becomes active. Choosing the highest-priority source and decoding register addresses are left to neighbouring logic.

Top module: `irq_pend_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, every bit of `pend_o` and `rect_o` is 0.
- R2: Mode codes are 0 Inactive, 1 Detached, 4 rising-edge, 5 falling-edge, 6 active-high level and 7 active-low level. `rect_o[i]` is the synchronized line for codes 4 and 6, its inverse for codes 5 and 7, and 0 otherwise. A raw line change reaches `rect_o` after exactly SYNC_STAGES rising clock edges.
- R3: In Detached mode, the pending bit rises only through a software write with value 1, seen in the cycle after the write. A claim or a software write with value 0 clears it.
- R4: In the two edge modes, a low-to-high change of `rect_o[i]` sets the pending bit one cycle after `rect_o[i]` rises. A software write of 1 also sets it. A claim or a software write of 0 clears it.
- R5: In the level modes, `pend_o[i]` equals `rect_o[i]` in every cycle. Software writes and claims have no effect on it.
- R6: Codes 2 and 3 are stored as Inactive. An Inactive source shows 0 on both `pend_o[i]` and `rect_o[i]`, and software writes do not set it.
- R7: A configuration write with the delegate bit set stores Inactive, whatever mode it carries. This clears the source's pending bit.
- R8: A configuration write takes effect in the next cycle. A level mode then shows the live input at once. Writing an edge mode while the rectified input is already high creates no edge. A write to Detached or an edge mode keeps the current pending value.
- R9: Writes, claims and inputs aimed at source 0 have no effect, and `pend_o[0]` and `rect_o[0]` are always 0.
- R10: When a set event (edge or software 1) and a clear event (claim or software 0) reach the same source in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_raw_i | input | NSRC | Raw interrupt lines, one per source |
| cfg_wr_en_i | input | 1 | Configuration write strobe |
| cfg_wr_id_i | input | ID_W | Source written by the configuration strobe |
| cfg_wr_mode_i | input | 3 | Mode code being written |
| cfg_wr_dlg_i | input | 1 | Delegate bit of the written configuration |
| pend_wr_en_i | input | 1 | Software pending write strobe |
| pend_wr_id_i | input | ID_W | Source of the pending write |
| pend_wr_val_i | input | 1 | 1 requests set, 0 requests clear |
| claim_en_i | input | 1 | Claim strobe from the handler |
| claim_id_i | input | ID_W | Source being claimed |
| pend_o | output | NSRC | Pending flags |
| rect_o | output | NSRC | Rectified input values |

## Verification
The bench builds the block with NSRC = 8 and SYNC_STAGES = 2. With these values, sources 0 and 7 (the reserved and the highest number) can be exercised together with one source in every mode, and the synchronizer latency of two edges can be timed exactly. The reference model tracks the modes, the delayed input history and the pending flags. It covers mode changes with pending state carried over, coincident set and clear events, and delegate writes on sources that hold a pending bit.

// File: rtl/irq_pend_pkg.sv
package irq_pend_pkg;

  typedef enum logic [2:0] {
    SM_OFF    = 3'd0,
    SM_DETACH = 3'd1,
    SM_RISE   = 3'd4,
    SM_FALL   = 3'd5,
    SM_HIGH   = 3'd6,
    SM_LOW    = 3'd7
  } src_mode_e;

  function automatic logic rectify(input logic [2:0] m, input logic v);
    case (m)
      SM_RISE, SM_HIGH: return v;
      SM_FALL, SM_LOW:  return ~v;
      default:          return 1'b0;
    endcase
  endfunction

  function automatic logic mode_is_level(input logic [2:0] m);
    return (m == SM_HIGH) || (m == SM_LOW);
  endfunction

  function automatic logic [2:0] legalize(input logic [2:0] m, input logic dlg);
    if (dlg) return SM_OFF;
    case (m)
      SM_DETACH, SM_RISE, SM_FALL, SM_HIGH, SM_LOW: return m;
      default: return SM_OFF;
    endcase
  endfunction

endpackage

// File: rtl/irq_sync_bank.sv
module irq_sync_bank #(
  parameter int NSRC   = 32,
  parameter int STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] raw_i,
  output logic [NSRC-1:0] cur_o,
  output logic [NSRC-1:0] prev_o
);
  logic [STAGES:0][NSRC-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-1:0], raw_i};
  end

  assign cur_o  = chain_q[STAGES-1];
  assign prev_o = chain_q[STAGES];
endmodule

// File: rtl/irq_cfg_bank.sv
module irq_cfg_bank import irq_pend_pkg::*; #(
  parameter int NSRC = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NSRC-1:0]       hit_i,
  input  logic [2:0]            mode_i,
  output logic [NSRC-1:0][2:0]  mode_o
);
  assign mode_o[0] = SM_OFF;

  for (genvar i = 1; i < NSRC; i++) begin : g_src
    logic [2:0] mode_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        mode_q <= SM_OFF;
      else if (hit_i[i]) mode_q <= mode_i;
    end
    assign mode_o[i] = mode_q;
  end
endmodule

// File: rtl/irq_pend_cell.sv
module irq_pend_cell import irq_pend_pkg::*; (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] mode_i,
  input  logic       cur_i,
  input  logic       prev_i,
  input  logic       set_i,
  input  logic       clr_i,
  input  logic       cfg_hit_i,
  input  logic [2:0] cfg_mode_i,
  output logic       pend_o,
  output logic       rect_o
);
  logic rect_prev, pend_q, pend_d;

  always_comb begin
    rect_o    = rectify(mode_i, cur_i);
    rect_prev = rectify(mode_i, prev_i);
    case (mode_i)
      SM_DETACH:       pend_d = set_i | (pend_q & ~clr_i);
      SM_RISE, SM_FALL: pend_d = set_i | (rect_o & ~rect_prev) | (pend_q & ~clr_i);
      SM_HIGH, SM_LOW: pend_d = rect_o;
      default:         pend_d = 1'b0;
    endcase
    if (cfg_hit_i && (cfg_mode_i == SM_OFF)) pend_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end

  assign pend_o = mode_is_level(mode_i) ? rect_o : pend_q;
endmodule

// File: rtl/irq_pend_ctrl.sv
module irq_pend_ctrl import irq_pend_pkg::*; #(
  parameter int NSRC        = 32,
  parameter int SYNC_STAGES = 2,
  localparam int ID_W       = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] irq_raw_i,
  input  logic            cfg_wr_en_i,
  input  logic [ID_W-1:0] cfg_wr_id_i,
  input  logic [2:0]      cfg_wr_mode_i,
  input  logic            cfg_wr_dlg_i,
  input  logic            pend_wr_en_i,
  input  logic [ID_W-1:0] pend_wr_id_i,
  input  logic            pend_wr_val_i,
  input  logic            claim_en_i,
  input  logic [ID_W-1:0] claim_id_i,
  output logic [NSRC-1:0] pend_o,
  output logic [NSRC-1:0] rect_o
);
  logic [NSRC-1:0]      sync_cur, sync_prev, cfg_hit;
  logic [NSRC-1:0][2:0] src_mode;
  logic [2:0]           new_mode;

  assign new_mode = legalize(cfg_wr_mode_i, cfg_wr_dlg_i);

  irq_sync_bank #(.NSRC(NSRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .raw_i(irq_raw_i),
    .cur_o(sync_cur), .prev_o(sync_prev)
  );

  irq_cfg_bank #(.NSRC(NSRC)) u_cfg (
    .clk(clk), .rst_n(rst_n), .hit_i(cfg_hit),
    .mode_i(new_mode), .mode_o(src_mode)
  );

  assign cfg_hit[0] = 1'b0;
  assign pend_o[0]  = 1'b0;
  assign rect_o[0]  = 1'b0;

  for (genvar i = 1; i < NSRC; i++) begin : g_cell
    logic wr_hit, set_ev, clr_ev;
    assign cfg_hit[i] = cfg_wr_en_i && (cfg_wr_id_i == ID_W'(i));
    assign wr_hit     = pend_wr_en_i && (pend_wr_id_i == ID_W'(i));
    assign set_ev     = wr_hit && pend_wr_val_i;
    assign clr_ev     = (wr_hit && !pend_wr_val_i) ||
                        (claim_en_i && (claim_id_i == ID_W'(i)));
    irq_pend_cell u_cell (
      .clk(clk), .rst_n(rst_n), .mode_i(src_mode[i]),
      .cur_i(sync_cur[i]), .prev_i(sync_prev[i]),
      .set_i(set_ev), .clr_i(clr_ev),
      .cfg_hit_i(cfg_hit[i]), .cfg_mode_i(new_mode),
      .pend_o(pend_o[i]), .rect_o(rect_o[i])
    );
  end
endmodule

// File: rtl/irq_pend_ctrl_chk.sv
module irq_pend_ctrl_chk import irq_pend_pkg::*; #(
  parameter int NSRC = 32,
  parameter int ID_W = 5
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NSRC-1:0][2:0] mode_i,
  input logic                 cfg_wr_en_i,
  input logic [ID_W-1:0]      cfg_wr_id_i,
  input logic                 pend_wr_en_i,
  input logic [ID_W-1:0]      pend_wr_id_i,
  input logic                 pend_wr_val_i,
  input logic                 claim_en_i,
  input logic [ID_W-1:0]      claim_id_i,
  input logic [NSRC-1:0]      pend_o,
  input logic [NSRC-1:0]      rect_o
);
  assert_id0_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !pend_o[0] && !rect_o[0]);

  for (genvar i = 1; i < NSRC; i++) begin : g_chk
    logic sw_set, cfg_hit, claim_hit;
    assign sw_set    = pend_wr_en_i && pend_wr_val_i && (pend_wr_id_i == ID_W'(i));
    assign cfg_hit   = cfg_wr_en_i && (cfg_wr_id_i == ID_W'(i));
    assign claim_hit = claim_en_i && (claim_id_i == ID_W'(i));

    assert_level_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
      mode_is_level(mode_i[i]) |-> (pend_o[i] == rect_o[i]));

    assert_inactive_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i[i] == SM_OFF) |-> (!pend_o[i] && !rect_o[i]));

    assert_detach_rect_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i[i] == SM_DETACH) |-> !rect_o[i]);

    assert_detach_sw_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ((mode_i[i] == SM_DETACH) && !sw_set && !cfg_hit) |=> !$rose(pend_o[i]));

    assert_detach_claim_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ((mode_i[i] == SM_DETACH) && claim_hit && !sw_set && !cfg_hit) |=> !pend_o[i]);
  end
endmodule

bind irq_pend_ctrl irq_pend_ctrl_chk #(.NSRC(NSRC), .ID_W(ID_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_i(src_mode),
  .cfg_wr_en_i(cfg_wr_en_i), .cfg_wr_id_i(cfg_wr_id_i),
  .pend_wr_en_i(pend_wr_en_i), .pend_wr_id_i(pend_wr_id_i),
  .pend_wr_val_i(pend_wr_val_i),
  .claim_en_i(claim_en_i), .claim_id_i(claim_id_i),
  .pend_o(pend_o), .rect_o(rect_o)
);

// File: tb/irq_pend_ctrl_bench.sv
module irq_pend_ctrl_bench;
  localparam int N  = 8;
  localparam int SS = 2;
  localparam int IW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] raw = '0;
  logic cfg_en = 1'b0, cfg_dlg = 1'b0, pw_en = 1'b0, pw_val = 1'b0, cl_en = 1'b0;
  logic [IW-1:0] cfg_id = '0, pw_id = '0, cl_id = '0;
  logic [2:0] cfg_mode = '0;
  logic [N-1:0] pend, rect;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  string cur_req = "R1";

  always #10 clk = ~clk;

  irq_pend_ctrl #(.NSRC(N), .SYNC_STAGES(SS)) u_irq_pend_ctrl (
    .clk(clk), .rst_n(rst_n), .irq_raw_i(raw),
    .cfg_wr_en_i(cfg_en), .cfg_wr_id_i(cfg_id), .cfg_wr_mode_i(cfg_mode),
    .cfg_wr_dlg_i(cfg_dlg), .pend_wr_en_i(pw_en), .pend_wr_id_i(pw_id),
    .pend_wr_val_i(pw_val), .claim_en_i(cl_en), .claim_id_i(cl_id),
    .pend_o(pend), .rect_o(rect)
  );

  // reference model
  int m_mode [N];
  bit m_pend [N];
  bit m_hist [N][$];

  function automatic bit m_rect(int md, bit v);
    if (md == 4 || md == 6) return v;
    if (md == 5 || md == 7) return !v;
    return 1'b0;
  endfunction

  function automatic logic [N-1:0] exp_rect();
    logic [N-1:0] r = '0;
    for (int i = 1; i < N; i++) r[i] = m_rect(m_mode[i], m_hist[i][SS-1]);
    return r;
  endfunction

  function automatic logic [N-1:0] exp_pend();
    logic [N-1:0] p = '0;
    logic [N-1:0] r = exp_rect();
    for (int i = 1; i < N; i++) p[i] = (m_mode[i] >= 6) ? r[i] : m_pend[i];
    return p;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin
        m_mode[i] = 0; m_pend[i] = 0; m_hist[i] = {};
        for (int k = 0; k <= SS; k++) m_hist[i].push_back(1'b0);
      end
    end else begin
      for (int i = 1; i < N; i++) begin
        bit rn, rp, st, cl, np;
        int nm;
        rn = m_rect(m_mode[i], m_hist[i][SS-1]);
        rp = m_rect(m_mode[i], m_hist[i][SS]);
        st = pw_en && pw_val && (int'(pw_id) == i);
        cl = (pw_en && !pw_val && (int'(pw_id) == i)) || (cl_en && (int'(cl_id) == i));
        if (m_mode[i] == 1)                         np = st ? 1'b1 : (cl ? 1'b0 : m_pend[i]);
        else if (m_mode[i] == 4 || m_mode[i] == 5)  np = (st || (rn && !rp)) ? 1'b1 : (cl ? 1'b0 : m_pend[i]);
        else if (m_mode[i] >= 6)                    np = rn;
        else                                        np = 1'b0;
        if (cfg_en && int'(cfg_id) == i) begin
          nm = int'(cfg_mode);
          if (cfg_dlg || nm == 2 || nm == 3) nm = 0;
          m_mode[i] = nm;
          if (nm == 0) np = 1'b0;
        end
        m_pend[i] = np;
      end
      for (int i = 0; i < N; i++) begin
        m_hist[i].push_front(raw[i]);
        void'(m_hist[i].pop_back());
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [N-1:0] ep, er;
      ep = exp_pend(); er = exp_rect();
      checks++;
      if (pend !== ep) begin
        errors++;
        $display("FAIL %s model pend got %b expected %b at %0t", cur_req, pend, ep, $time);
      end
      checks++;
      if (rect !== er) begin
        errors++;
        $display("FAIL %s model rect got %b expected %b at %0t", cur_req, rect, er, $time);
      end
    end
  end

  task automatic chk(string req, logic [N-1:0] got, logic [N-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %b expected %b", req, got, exp);
    end
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cfg(int id, int md, bit dlg);
    @(negedge clk);
    cfg_en = 1'b1; cfg_id = IW'(id); cfg_mode = 3'(md); cfg_dlg = dlg;
    @(negedge clk);
    cfg_en = 1'b0; cfg_dlg = 1'b0;
  endtask

  task automatic swr(int id, bit v);
    @(negedge clk);
    pw_en = 1'b1; pw_id = IW'(id); pw_val = v;
    @(negedge clk);
    pw_en = 1'b0;
  endtask

  task automatic claim(int id);
    @(negedge clk);
    cl_en = 1'b1; cl_id = IW'(id);
    @(negedge clk);
    cl_en = 1'b0;
  endtask

  task automatic set_raw(int id, bit v);
    @(negedge clk);
    raw[id] = v;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    cur_req = "R1";
    wait_cyc(3);
    chk("R1 reset pend", pend, '0);
    chk("R1 reset rect", rect, '0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after reset pend", pend, '0);

    cur_req = "R2";
    cfg(1, 4, 0); cfg(2, 5, 0); cfg(3, 6, 0); cfg(4, 7, 0);
    cfg(5, 1, 0); cfg(6, 2, 0); cfg(7, 0, 0);
    wait_cyc(4);
    chk("R2 rectified setup", rect, 8'h14);
    chk("R8 level0 live, falling edge silent", pend, 8'h10);

    cur_req = "R4";
    set_raw(1, 1); wait_cyc(4);
    chk("R4 rising edge sets", pend, 8'h12);
    claim(1);
    chk("R4 claim clears", pend, 8'h10);
    set_raw(2, 1); wait_cyc(4);
    chk("R4 falling-edge source no set on rect fall", pend, 8'h10);
    set_raw(2, 0); wait_cyc(4);
    chk("R4 falling-edge source sets", pend, 8'h14);
    swr(2, 0);
    chk("R4 sw clear", pend, 8'h10);
    swr(1, 1);
    chk("R4 sw set", pend, 8'h12);

    cur_req = "R5";
    set_raw(3, 1); wait_cyc(4);
    chk("R5 level follows", pend, 8'h1A);
    swr(3, 0); claim(3);
    chk("R5 clear ignored", pend, 8'h1A);
    set_raw(3, 0); wait_cyc(4);
    swr(3, 1);
    chk("R5 set ignored", pend, 8'h12);

    cur_req = "R3";
    set_raw(5, 1); wait_cyc(4);
    chk("R3 input ignored pend", pend, 8'h12);
    chk("R3 input ignored rect", rect, 8'h16);
    swr(5, 1);
    chk("R3 sw set", pend, 8'h32);
    claim(5);
    chk("R3 claim clears", pend, 8'h12);
    swr(5, 1); swr(5, 0);
    chk("R3 sw clear", pend, 8'h12);

    cur_req = "R10";
    @(negedge clk);
    pw_en = 1'b1; pw_id = 3'd5; pw_val = 1'b1; cl_en = 1'b1; cl_id = 3'd5;
    @(negedge clk);
    pw_en = 1'b0; cl_en = 1'b0;
    chk("R10 set beats claim", pend, 8'h32);

    cur_req = "R7";
    cfg(5, 1, 1);
    chk("R7 delegate clears pending", pend, 8'h12);
    swr(5, 1);
    chk("R7 delegated source inactive", pend, 8'h12);
    set_raw(3, 1);
    cfg(3, 6, 1); wait_cyc(4);
    chk("R7 delegate level source quiet", rect, 8'h16);
    chk("R7 delegate level source pend", pend, 8'h12);

    cur_req = "R9";
    cfg(0, 7, 0); swr(0, 1); set_raw(0, 1); claim(0); wait_cyc(4);
    chk("R9 id0 pend", pend, 8'h12);
    chk("R9 id0 rect", rect, 8'h16);

    cur_req = "R6";
    set_raw(6, 1); swr(6, 1); wait_cyc(4);
    chk("R6 illegal code pend", pend, 8'h12);
    chk("R6 illegal code rect", rect, 8'h16);

    cur_req = "R8";
    cfg(3, 6, 0);
    chk("R8 level shows live input at once", pend, 8'h1A);
    cfg(3, 1, 0);
    chk("R8 detached keeps pending", pend, 8'h1A);
    cfg(1, 5, 0);
    chk("R8 edge mode keeps pending", pend, 8'h1A);
    swr(1, 0);
    chk("R8 cleared", pend, 8'h18);

    cur_req = "R2";
    @(negedge clk); raw[1] = 1'b0;
    @(negedge clk);
    chk("R2 one edge: rect unchanged", rect & 8'h02, 8'h00);
    @(negedge clk);
    chk("R2 two edges: rect updated", rect & 8'h02, 8'h02);
    wait_cyc(2);
    chk("R4 falling line sets edge", pend, 8'h1A);

    wait_cyc(2);
    finish_run();
  end
endmodule